// File: doc/BRIEF.md
# LCD Panel Raster Timing Generator

This block produces the raster timing for a TFT panel, working directly in the pixel clock domain. A horizontal counter steps once per clock. A line counter steps each time the horizontal counter wraps. Each timing edge is a programmable window, given as a 32-bit word: the start position sits in bits 31:16 and the end position in bits 15:0. The window words describe the line sync pulse, the frame sync pulse, the active horizontal span and the active vertical span. A separate length word carries the line and frame totals.

From these windows the block drives line sync, frame sync and data-enable. It also reports the pixel coordinates inside the active area and gives a strobe for each new pixel. A polarity input can invert each of line sync, frame sync and the pixel qualifier. A serial RGB mode sends each pixel as three byte-wide beats, so every active pixel is held for three clocks.

Configuration is captured into shadow registers when the block starts and again at every frame boundary, so a frame never mixes two configurations. Dropping the run input lets the current frame finish before the block stops. The quick-stop input halts it at once.

Top module: `lcd_raster_gen`

## Requirements
- R1: While `rst` is high, and until the block is started, `active`, `hsync`, `vsync`, `de`, `pix_stb`, `pclk_out`, `pix_x` and `pix_y` are all 0.
- R2: When `run_en` is high in a cycle where the block is idle (and `quick_stop` is low), the block starts counting from column 0, line 0. Each output reflects a counter position one clock edge after that position is reached.
- R3: The column counter wraps to 0 after reaching (line total − 1), where the line total is in bits 31:16 of `total_cfg`. At each column wrap the line counter steps. The line counter wraps to 0 after reaching (frame total − 1), where the frame total is in bits 15:0 of `total_cfg`.
- R4: Line sync is active while the column is ≥ start and < end of `hsync_cfg`. Frame sync is active while the line is ≥ start and < end of `vsync_cfg` (start in bits 31:16, end in bits 15:0, both end-exclusive).
- R5: `de` is high exactly when the column is inside the horizontal active window AND the line is inside the vertical active window. Both windows are end-exclusive and take start from bits 31:16 and end from bits 15:0 of `hact_cfg` / `vact_cfg`. `de` is low whenever the block is not running.
- R6: While `de` is high, `pix_x` is the pixel index from the horizontal window start and `pix_y` is line − vertical start. Both are 0 while `de` is low. In normal mode `pix_stb` is high on every `de` cycle.
- R7: With `serial_rgb` set, the horizontal active window ends at start + 3 × (end − start). `pix_x` advances every third clock, and `pix_stb` is high only on the first of the three clocks of each pixel.
- R8: `inv_hsync`, `inv_vsync` and `inv_pclk` invert `hsync`, `vsync` and `pclk_out` respectively. `pclk_out` is `pix_stb` XOR `inv_pclk`.
- R9: The configuration inputs are captured only at start and at each frame wrap. Changes made mid-frame have no effect until the next frame.
- R10: If `run_en` is low at the last position of a frame, `active` falls at that wrap. Until then the frame runs to its end.
- R11: `quick_stop` drops `active` at the next edge and clears both counters. Outputs go inactive one edge later. While `quick_stop` is held, the block stays idle even with `run_en` high. The next start begins again at column 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start / keep running; low requests a stop at frame end |
| quick_stop | input | 1 | Immediate halt |
| hsync_cfg | input | 32 | Line sync window, start[31:16] end[15:0] |
| vsync_cfg | input | 32 | Frame sync window, start[31:16] end[15:0] |
| hact_cfg | input | 32 | Horizontal active window |
| vact_cfg | input | 32 | Vertical active window |
| total_cfg | input | 32 | Line total [31:16], frame total [15:0] |
| serial_rgb | input | 1 | Three clocks per active pixel |
| inv_pclk | input | 1 | Invert pixel qualifier output |
| inv_hsync | input | 1 | Invert line sync |
| inv_vsync | input | 1 | Invert frame sync |
| active | output | 1 | Counters running |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Pixel column inside active area |
| pix_y | output | 16 | Pixel line inside active area |
| pix_stb | output | 1 | New-pixel strobe |
| pclk_out | output | 1 | Pixel qualifier with polarity applied |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the frame wrap, which reloads the shadow configuration, and a stop request. The bench drops `run_en` mid-frame and samples `active` on the last position of the frame and on the first position after it. This proves the stop waits for the wrap and that the wrap still takes place. The second pair is a mid-frame edit of the horizontal window and the frame boundary that adopts it. The bench probes the same column in the frame of the edit and in the frame that follows, and expects `de` to change only in the second.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  localparam int unsigned SPAN_W = 16;
  localparam int unsigned WORD_W = 2 * SPAN_W;

  typedef struct packed {
    logic [SPAN_W-1:0] first;
    logic [SPAN_W-1:0] last;
  } span_t;

  typedef struct packed {
    span_t             hs;
    span_t             vs;
    span_t             ha;
    span_t             va;
    logic [SPAN_W-1:0] htot;
    logic [SPAN_W-1:0] vtot;
    logic              serial;
  } timing_t;

  function automatic span_t to_span(input logic [WORD_W-1:0] w);
    span_t s;
    s.first = w[WORD_W-1:SPAN_W];
    s.last  = w[SPAN_W-1:0];
    return s;
  endfunction

endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] hs_word,
  input  logic [WORD_W-1:0] vs_word,
  input  logic [WORD_W-1:0] ha_word,
  input  logic [WORD_W-1:0] va_word,
  input  logic [WORD_W-1:0] tot_word,
  input  logic              serial_in,
  output timing_t           cur
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load) begin
      cur.hs     <= to_span(hs_word);
      cur.vs     <= to_span(vs_word);
      cur.ha     <= to_span(ha_word);
      cur.va     <= to_span(va_word);
      cur.htot   <= tot_word[WORD_W-1:SPAN_W];
      cur.vtot   <= tot_word[SPAN_W-1:0];
      cur.serial <= serial_in;
    end
  end

  // R9: configuration only moves when a load is granted
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur));

endmodule

// File: rtl/lcd_raster_counter.sv
module lcd_raster_counter
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              quick_stop,
  input  logic [SPAN_W-1:0] htot,
  input  logic [SPAN_W-1:0] vtot,
  output logic              running,
  output logic [SPAN_W-1:0] hcnt,
  output logic [SPAN_W-1:0] vcnt,
  output logic              load
);

  localparam logic [SPAN_W-1:0] ONE = SPAN_W'(1);

  logic h_last, v_last, frame_end, start;

  assign h_last    = (hcnt == htot - ONE);
  assign v_last    = (vcnt == vtot - ONE);
  assign frame_end = running && h_last && v_last;
  assign start     = !running && run_en && !quick_stop;
  assign load      = start || (frame_end && !quick_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (quick_stop) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      running <= run_en;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      if (v_last) begin
        vcnt    <= '0;
        running <= run_en;
      end else begin
        vcnt <= vcnt + ONE;
      end
    end else begin
      hcnt <= hcnt + ONE;
    end
  end

  // R3: the column never passes the programmed line total
  p_hcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (running && htot != '0) |-> (hcnt < htot));

  // R11: quick stop halts and clears at the next edge
  p_quick_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (running && quick_stop) |=> (!running && hcnt == '0 && vcnt == '0));

  // R10: without quick stop, running only ends on a frame boundary
  p_stop_at_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (running && !quick_stop && !(h_last && v_last)) |=> running);

endmodule

// File: rtl/lcd_window_out.sv
module lcd_window_out
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic [SPAN_W-1:0] hcnt,
  input  logic [SPAN_W-1:0] vcnt,
  input  span_t             hs_span,
  input  span_t             vs_span,
  input  span_t             ha_span,
  input  span_t             va_span,
  input  logic              serial,
  input  logic              inv_pclk,
  input  logic              inv_hs,
  input  logic              inv_vs,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [SPAN_W-1:0] pix_x_o,
  output logic [SPAN_W-1:0] pix_y_o,
  output logic              pix_stb_o,
  output logic              pclk_o
);

  localparam int unsigned CMP_W = SPAN_W + 2;
  localparam int unsigned NWIN  = 4;
  localparam logic [1:0]  LAST_BEAT = 2'd2;

  logic [CMP_W-1:0]  lo  [NWIN];
  logic [CMP_W-1:0]  hi  [NWIN];
  logic [CMP_W-1:0]  pos [NWIN];
  logic [NWIN-1:0]   hit;
  logic [SPAN_W-1:0] ha_width;
  logic [CMP_W-1:0]  ha_end_eff;

  assign ha_width   = ha_span.last - ha_span.first;
  assign ha_end_eff = serial ? ({2'b00, ha_span.first} + ({2'b00, ha_width} * CMP_W'(3)))
                             : {2'b00, ha_span.last};

  always_comb begin
    lo[0]  = {2'b00, hs_span.first};  hi[0] = {2'b00, hs_span.last};  pos[0] = {2'b00, hcnt};
    lo[1]  = {2'b00, vs_span.first};  hi[1] = {2'b00, vs_span.last};  pos[1] = {2'b00, vcnt};
    lo[2]  = {2'b00, ha_span.first};  hi[2] = ha_end_eff;             pos[2] = {2'b00, hcnt};
    lo[3]  = {2'b00, va_span.first};  hi[3] = {2'b00, va_span.last};  pos[3] = {2'b00, vcnt};
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit[i] = running && (pos[i] >= lo[i]) && (pos[i] < hi[i]);
  end

  logic              de_win;
  logic [SPAN_W-1:0] px_r, nx_px;
  logic [1:0]        sub_r, nx_sub;
  logic              fresh;

  assign de_win = hit[2] && hit[3];

  always_comb begin
    nx_px  = px_r;
    nx_sub = 2'd0;
    fresh  = 1'b0;
    if (hit[2]) begin
      if (hcnt == ha_span.first) begin
        nx_px = '0;
        fresh = 1'b1;
      end else if (serial && sub_r != LAST_BEAT) begin
        nx_sub = sub_r + 2'd1;
      end else begin
        nx_px = px_r + SPAN_W'(1);
        fresh = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      px_r      <= '0;
      sub_r     <= '0;
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
      pix_x_o   <= '0;
      pix_y_o   <= '0;
      pix_stb_o <= 1'b0;
      pclk_o    <= 1'b0;
    end else begin
      px_r      <= nx_px;
      sub_r     <= nx_sub;
      hsync_o   <= hit[0] ^ inv_hs;
      vsync_o   <= hit[1] ^ inv_vs;
      de_o      <= de_win;
      pix_x_o   <= de_win ? nx_px : '0;
      pix_y_o   <= de_win ? (vcnt - va_span.first) : '0;
      pix_stb_o <= de_win && fresh;
      pclk_o    <= (de_win && fresh) ^ inv_pclk;
    end
  end

  // R6: every run of data-enable begins at pixel column zero
  p_first_pixel_r6: assert property (@(posedge clk) disable iff (rst)
    (de_o && !$past(de_o)) |-> (pix_x_o == '0));

  // R7: in serial mode two strobes are never adjacent
  p_serial_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (serial && $past(serial) && pix_stb_o) |=> !pix_stb_o);

  // R5: data-enable drops once the counters have stopped
  p_de_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !running |=> !de_o);

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              quick_stop,
  input  logic [WORD_W-1:0] hsync_cfg,
  input  logic [WORD_W-1:0] vsync_cfg,
  input  logic [WORD_W-1:0] hact_cfg,
  input  logic [WORD_W-1:0] vact_cfg,
  input  logic [WORD_W-1:0] total_cfg,
  input  logic              serial_rgb,
  input  logic              inv_pclk,
  input  logic              inv_hsync,
  input  logic              inv_vsync,
  output logic              active,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [SPAN_W-1:0] pix_x,
  output logic [SPAN_W-1:0] pix_y,
  output logic              pix_stb,
  output logic              pclk_out
);

  timing_t           tim;
  logic              load;
  logic              running;
  logic [SPAN_W-1:0] hcnt, vcnt;

  lcd_cfg_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .hs_word   (hsync_cfg),
    .vs_word   (vsync_cfg),
    .ha_word   (hact_cfg),
    .va_word   (vact_cfg),
    .tot_word  (total_cfg),
    .serial_in (serial_rgb),
    .cur       (tim)
  );

  lcd_raster_counter u_count (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .quick_stop (quick_stop),
    .htot       (tim.htot),
    .vtot       (tim.vtot),
    .running    (running),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .load       (load)
  );

  lcd_window_out u_out (
    .clk       (clk),
    .rst       (rst),
    .running   (running),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .hs_span   (tim.hs),
    .vs_span   (tim.vs),
    .ha_span   (tim.ha),
    .va_span   (tim.va),
    .serial    (tim.serial),
    .inv_pclk  (inv_pclk),
    .inv_hs    (inv_hsync),
    .inv_vs    (inv_vsync),
    .hsync_o   (hsync),
    .vsync_o   (vsync),
    .de_o      (de),
    .pix_x_o   (pix_x),
    .pix_y_o   (pix_y),
    .pix_stb_o (pix_stb),
    .pclk_o    (pclk_out)
  );

  assign active = running;

endmodule

// File: tb/tb_lcd_raster_gen.sv
`timescale 1ns/1ps
module tb_lcd_raster_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        quick_stop = 1'b0;
  logic [31:0] hsync_cfg = '0, vsync_cfg = '0, hact_cfg = '0, vact_cfg = '0, total_cfg = '0;
  logic        serial_rgb = 1'b0, inv_pclk = 1'b0, inv_hsync = 1'b0, inv_vsync = 1'b0;
  logic        active, hsync, vsync, de, pix_stb, pclk_out;
  logic [15:0] pix_x, pix_y;

  always #2 clk = ~clk;

  lcd_raster_gen dut (
    .clk(clk), .rst(rst), .run_en(run_en), .quick_stop(quick_stop),
    .hsync_cfg(hsync_cfg), .vsync_cfg(vsync_cfg), .hact_cfg(hact_cfg),
    .vact_cfg(vact_cfg), .total_cfg(total_cfg), .serial_rgb(serial_rgb),
    .inv_pclk(inv_pclk), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync),
    .active(active), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .pix_stb(pix_stb), .pclk_out(pclk_out)
  );

  typedef struct packed {
    logic [31:0] hs, vs, ha, va, tot;
    logic        ser, ihs, ivs, ipc;
    logic [15:0] hc, vc;
    logic        e_hs, e_vs, e_de, e_stb, e_pc;
    logic [15:0] ex, ey;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd0,16'd0, 1'b1,1'b1,1'b0,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd3,16'd2, 1'b0,1'b0,1'b1,1'b1,1'b1, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd6,16'd4, 1'b0,1'b0,1'b1,1'b1,1'b1, 16'd3,16'd2},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd7,16'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd4,16'd5, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b0,1'b0,1'b0, 16'd2,16'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0005, 32'h0001_0003, 32'h000C_0004, 1'b1,1'b0,1'b0,1'b0, 16'd3,16'd1, 1'b0,1'b0,1'b1,1'b1,1'b1, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0005, 32'h0001_0003, 32'h000C_0004, 1'b1,1'b0,1'b0,1'b0, 16'd4,16'd1, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0005, 32'h0001_0003, 32'h000C_0004, 1'b1,1'b0,1'b0,1'b0, 16'd6,16'd1, 1'b0,1'b0,1'b1,1'b1,1'b1, 16'd1,16'd0},
    '{32'h2, 32'h1, 32'h0003_0005, 32'h0001_0003, 32'h000C_0004, 1'b1,1'b0,1'b0,1'b0, 16'd8,16'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'd1,16'd1},
    '{32'h2, 32'h1, 32'h0003_0005, 32'h0001_0003, 32'h000C_0004, 1'b1,1'b0,1'b0,1'b0, 16'd9,16'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b1,1'b1,1'b1, 16'd3,16'd2, 1'b1,1'b1,1'b1,1'b1,1'b0, 16'd0,16'd0},
    '{32'h2, 32'h1, 32'h0003_0007, 32'h0002_0005, 32'h000A_0006, 1'b0,1'b1,1'b1,1'b1, 16'd0,16'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 16'd0,16'd0}
  };

  int n_chk = 0, n_bad = 0, pos = -1;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic halt();
    @(negedge clk); run_en = 1'b0; quick_stop = 1'b1;
    @(posedge clk);
    @(negedge clk); quick_stop = 1'b0;
  endtask

  task automatic cfg_a();
    hsync_cfg = 32'h2; vsync_cfg = 32'h1; hact_cfg = 32'h0003_0007;
    vact_cfg = 32'h0002_0005; total_cfg = 32'h000A_0006;
    serial_rgb = 1'b0; inv_hsync = 1'b0; inv_vsync = 1'b0; inv_pclk = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); quick_stop = 1'b0; run_en = 1'b1;
    @(posedge clk);
    pos = -1;
  endtask

  task automatic advance(input int k);
    repeat (k - pos) @(posedge clk);
    @(negedge clk);
    pos = k;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 active in reset", 32'(active), 0);
    chk("R1 outputs in reset", {hsync, vsync, de, pix_stb, pclk_out, pix_x, pix_y}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {active, hsync, vsync, de, pix_stb}, 0);

    // vector table: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      halt();
      hsync_cfg = VECS[i].hs; vsync_cfg = VECS[i].vs; hact_cfg = VECS[i].ha;
      vact_cfg = VECS[i].va; total_cfg = VECS[i].tot; serial_rgb = VECS[i].ser;
      inv_hsync = VECS[i].ihs; inv_vsync = VECS[i].ivs; inv_pclk = VECS[i].ipc;
      start();
      advance(int'(VECS[i].vc) * int'(VECS[i].tot[31:16]) + int'(VECS[i].hc));
      chk(VECS[i].ihs ? "R8 hsync" : "R4 hsync", 32'(hsync), 32'(VECS[i].e_hs));
      chk(VECS[i].ivs ? "R8 vsync" : "R4 vsync", 32'(vsync), 32'(VECS[i].e_vs));
      chk("R5 de", 32'(de), 32'(VECS[i].e_de));
      chk(VECS[i].ser ? "R7 pix_stb" : "R6 pix_stb", 32'(pix_stb), 32'(VECS[i].e_stb));
      chk(VECS[i].ser ? "R7 pix_x" : "R6 pix_x", 32'(pix_x), 32'(VECS[i].ex));
      chk("R6 pix_y", 32'(pix_y), 32'(VECS[i].ey));
      chk("R8 pclk_out", 32'(pclk_out), 32'(VECS[i].e_pc));
    end

    // R2 R3: start at origin, wraps of column and line
    halt(); cfg_a(); start();
    advance(0);
    chk("R2 active after start", 32'(active), 1);
    chk("R2 origin sync", {hsync, vsync}, 2'b11);
    advance(60);
    chk("R3 frame wrap to origin", {active, hsync, vsync}, 3'b111);
    advance(83);
    chk("R3 second frame de", {de, pix_stb}, 2'b11);
    chk("R3 second frame y", 32'(pix_y), 0);

    // R9: mid-frame change lands at next frame
    halt(); cfg_a(); start();
    advance(5);
    hact_cfg = 32'h0005_0007;
    advance(33);
    chk("R9 old window kept", 32'(de), 1);
    advance(93);
    chk("R9 new window start", 32'(de), 0);
    advance(95);
    chk("R9 new window x", {de, pix_x}, {1'b1, 16'd0});

    // R10: regular stop waits for frame end
    halt(); cfg_a(); start();
    advance(15);
    run_en = 1'b0;
    advance(58);
    chk("R10 still running", 32'(active), 1);
    advance(59);
    chk("R10 stopped at wrap", 32'(active), 0);
    advance(60);
    chk("R10 no new frame", {hsync, vsync, de}, 0);

    // R11: quick stop and restart
    halt(); cfg_a(); start();
    advance(25);
    chk("R11 running pre-stop", {de, pix_x}, {1'b1, 16'd2});
    quick_stop = 1'b1; run_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11 active drops", 32'(active), 0);
    run_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 outputs quiet", {de, pix_stb, hsync}, 0);
    repeat (3) @(negedge clk);
    chk("R11 held idle", 32'(active), 0);
    start();
    advance(0);
    chk("R11 restart at origin", {active, hsync, vsync, de}, 4'b1110);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule